// File: doc/BRIEF.md
# Asynchronous Serial Port with Ninth-Bit Support

This block is a full-duplex asynchronous serial port for a small microcontroller subsystem. Software drives it through two register locations chosen by a one-bit select: a control register holding the operating mode, the receive enable, the address-filter enable, the outgoing and incoming ninth bits and the two completion flags, and a data location. A write to the data location launches a frame on the transmit line. A read of it returns the most recently accepted received byte.

Three framed formats are available. One uses eight data bits. Two use nine, where the extra bit comes from a control bit on transmit and lands in another control bit on receive. Bit timing comes either from an external timer overflow pulse or from a free-running oscillator tick, with a doubling input that halves the bit time. The receiver oversamples the line sixteen times per bit, votes on the three middle samples and drops a start bit that does not hold. An address filter lets a node ignore frames whose ninth bit, or stop bit in the eight-bit format, is clear. A received frame is discarded while the receive flag is still set from the previous one.

Top module: `srl_port`

## Requirements
- R1: After reset the control register reads 0x00, the data location reads 0x00, `txd` is 1 and `ti` and `ri` are 0.
- R2: The control register fields are, from bit 7 down: mode high, mode low, address filter, receive enable, transmit ninth bit, receive ninth bit, transmit-done flag (bit 1, driven on `ti`), receive flag (bit 0, driven on `ri`). All eight bits are software writable and read back as written; the flags fall only through a control write.
- R3: In mode 01 a write to the data location (`reg_sel`=1) sends a 0 start bit, eight data bits least significant first and a 1 stop bit; the transmit-done flag rises only after the stop bit time has ended.
- R4: In modes 10 and 11 the frame carries a ninth bit, equal to control bit 3, between the eighth data bit and the stop bit.
- R5: One bit lasts 32 `t1_ovf` pulses in modes 01 and 11, or 16 with `smod`=1; in mode 10 it lasts 64 `osc_tick` pulses, or 32 with `smod`=1. The time from the start edge to the rise of the transmit-done flag is the frame length in bits times the bit time, less at most one sixteenth of a bit.
- R6: With receive enable set and the address filter clear, a complete frame is loaded into the data location, the receive flag is set and control bit 2 takes the ninth bit (modes 10/11) or the received stop bit (mode 01), even when that stop bit is 0.
- R7: With receive enable clear, no frame is received: the receive flag stays 0 and the data location keeps its value.
- R8: A low pulse on `rxd` shorter than half a bit is treated as a false start; nothing is received and a following valid frame is received correctly.
- R9: Each received bit is the majority of samples 7, 8 and 9 of its sixteen, so a one-sample glitch near mid-bit does not change the received data.
- R10: In modes 10/11 with the address filter set, a frame whose ninth bit is 0 is dropped (no flag, data unchanged); one whose ninth bit is 1 is accepted with control bit 2 set.
- R11: In mode 01 with the address filter set, a frame with a 0 stop bit is dropped and a frame with a 1 stop bit is accepted.
- R12: While the receive flag is set, a new frame is dropped: the data location and control bit 2 keep their previous values.
- R13: In mode 00 neither direction operates: a data write leaves `txd` at 1 and the transmit-done flag at 0, and frames on `rxd` are not received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator-derived rate pulse for mode 10 |
| t1_ovf | input | 1 | Timer overflow pulse for modes 01 and 11 |
| smod | input | 1 | Bit-rate doubling |
| reg_sel | input | 1 | 0 selects control register, 1 selects data location |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected location |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive flag |

## Verification
The assertions assume the flags change only through hardware events or a control write, and that `rxd` is driven with whole bits at the configured bit time apart from deliberate short glitches. The bench keeps the rate pulses steady during a frame, changes mode and doubling only while both directions are idle, and drives the line from a model that knows the bit time computed from the requirement arithmetic. Glitches and false starts are sized against that bit time so that each lands inside the window it is meant to probe.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_U8    = 2'b01,
    MODE_U9FIX = 2'b10,
    MODE_U9TMR = 2'b11
  } srl_mode_e;

  localparam int unsigned CB_MODE_HI = 7;
  localparam int unsigned CB_MODE_LO = 6;
  localparam int unsigned CB_FILT    = 5;
  localparam int unsigned CB_RXEN    = 4;
  localparam int unsigned CB_TX9     = 3;
  localparam int unsigned CB_RX9     = 2;
  localparam int unsigned CB_TXF     = 1;
  localparam int unsigned CB_RXF     = 0;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/srl_baud_gen.sv
module srl_baud_gen
  import srl_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int TMR_DIV = 32,
  parameter int OSC_DIV = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  srl_mode_e mode,
  input  logic      smod,
  input  logic      osc_tick,
  input  logic      t1_ovf,
  output logic      samp_tick
);

  localparam int TMR_PRE = TMR_DIV / OVS;
  localparam int OSC_PRE = OSC_DIV / OVS;
  localparam int PRE_MAX = (TMR_PRE > OSC_PRE) ? TMR_PRE : OSC_PRE;
  localparam int PRE_W   = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] lim;
  logic             src;

  always_comb begin
    src = 1'b0;
    lim = '0;
    unique case (mode)
      MODE_U9FIX: begin
        src = osc_tick;
        lim = smod ? PRE_W'(OSC_PRE / 2 - 1) : PRE_W'(OSC_PRE - 1);
      end
      MODE_U8, MODE_U9TMR: begin
        src = t1_ovf;
        lim = smod ? PRE_W'(TMR_PRE / 2 - 1) : PRE_W'(TMR_PRE - 1);
      end
      default: begin
        src = 1'b0;
        lim = '0;
      end
    endcase
  end

  always_comb begin
    pre_d     = pre_q;
    samp_tick = 1'b0;
    if (src) begin
      if (pre_q >= lim) begin
        pre_d     = '0;
        samp_tick = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/srl_tx.sv
module srl_tx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp_tick,
  input  logic              start,
  input  logic              nine,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              done
);

  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(OVS);
  localparam int LEFT_W    = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]    left_q, left_d;
  logic [CNT_W-1:0]     ph_q, ph_d;
  logic                 busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    ph_d   = ph_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        sh_d   = {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
        left_d = nine ? LEFT_W'(FRAME_MAX) : LEFT_W'(FRAME_MAX - 1);
        ph_d   = '0;
        busy_d = 1'b1;
      end
    end else if (samp_tick) begin
      if (ph_q == CNT_W'(OVS - 1)) begin
        ph_d = '0;
        if (left_q == LEFT_W'(1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          sh_d   = {1'b1, sh_q[FRAME_MAX-1:1]};
          left_d = left_q - 1'b1;
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
    end
  end

  assign txd = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/srl_rx.sv
module srl_rx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp_tick,
  input  logic              rxd_s,
  input  logic              nine,
  input  logic              filt,
  input  logic              hold,
  output logic              load,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_bit9
);

  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(OVS);
  localparam int IDX_W     = $clog2(FRAME_MAX);
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS / 2 + 1);

  logic                act_q, act_d;
  logic [CNT_W-1:0]    ph_q, ph_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                sa_q, sa_d, sb_q, sb_d;
  logic [DATA_W-1:0]   dat_q, dat_d;
  logic                b9_q, b9_d;
  logic                vote;
  logic [IDX_W-1:0]    last_idx;

  assign vote     = (sa_q & sb_q) | (sa_q & rxd_s) | (sb_q & rxd_s);
  assign last_idx = nine ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign ld_bit9  = nine ? b9_q : vote;
  assign ld_data  = dat_q;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    dat_d = dat_q;
    b9_d  = b9_q;
    load  = 1'b0;
    if (!en) begin
      act_d = 1'b0;
    end else if (samp_tick) begin
      if (!act_q) begin
        if (!rxd_s) begin
          act_d = 1'b1;
          ph_d  = '0;
          idx_d = '0;
        end
      end else begin
        if (ph_q == CNT_W'(OVS - 1)) begin
          ph_d  = '0;
          idx_d = idx_q + 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
        if (ph_q == SMP_A) sa_d = rxd_s;
        if (ph_q == SMP_B) sb_d = rxd_s;
        if (ph_q == SMP_C) begin
          if (idx_q == '0) begin
            if (vote) act_d = 1'b0;
          end else if (idx_q == last_idx) begin
            act_d = 1'b0;
            load  = !hold && (!filt || ld_bit9);
          end else if (idx_q <= IDX_W'(DATA_W)) begin
            dat_d = {vote, dat_q[DATA_W-1:1]};
          end else begin
            b9_d = vote;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      idx_q <= '0;
      sa_q  <= 1'b1;
      sb_q  <= 1'b1;
      dat_q <= '0;
      b9_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      idx_q <= idx_d;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      dat_q <= dat_d;
      b9_q  <= b9_d;
    end
  end

endmodule

// File: rtl/srl_port.sv
module srl_port
  import srl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int TMR_DIV = 32,
  parameter int OSC_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              t1_ovf,
  input  logic              smod,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              ti,
  output logic              ri
);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              rx_meta_q, rx_sync_q;
  srl_mode_e         mode;
  logic              samp_tick;
  logic              tx_done;
  logic              rx_load;
  logic [DATA_W-1:0] rx_data;
  logic              rx_bit9;
  logic              port_on;
  logic              ctrl_wr, data_wr;

  assign mode    = srl_mode_e'(ctrl_q[CB_MODE_HI:CB_MODE_LO]);
  assign port_on = (mode != MODE_OFF);
  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign data_wr = reg_wr && (reg_sel == SEL_DATA);

  srl_baud_gen #(.OVS(OVS), .TMR_DIV(TMR_DIV), .OSC_DIV(OSC_DIV)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .smod      (smod),
    .osc_tick  (osc_tick),
    .t1_ovf    (t1_ovf),
    .samp_tick (samp_tick)
  );

  srl_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (port_on),
    .samp_tick (samp_tick),
    .start     (data_wr),
    .nine      (ctrl_q[CB_MODE_HI]),
    .data      (reg_wdata),
    .bit9      (ctrl_q[CB_TX9]),
    .txd       (txd),
    .done      (tx_done)
  );

  srl_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (port_on && ctrl_q[CB_RXEN]),
    .samp_tick (samp_tick),
    .rxd_s     (rx_sync_q),
    .nine      (ctrl_q[CB_MODE_HI]),
    .filt      (ctrl_q[CB_FILT]),
    .hold      (ctrl_q[CB_RXF]),
    .load      (rx_load),
    .ld_data   (rx_data),
    .ld_bit9   (rx_bit9)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    rxbuf_d = rxbuf_q;
    if (ctrl_wr) ctrl_d = reg_wdata;
    if (tx_done) ctrl_d[CB_TXF] = 1'b1;
    if (rx_load) begin
      ctrl_d[CB_RXF] = 1'b1;
      ctrl_d[CB_RX9] = rx_bit9;
      rxbuf_d        = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rxbuf_q   <= '0;
      rx_meta_q <= 1'b1;
      rx_sync_q <= 1'b1;
    end else begin
      ctrl_q    <= ctrl_d;
      rxbuf_q   <= rxbuf_d;
      rx_meta_q <= rxd;
      rx_sync_q <= rx_meta_q;
    end
  end

  assign reg_rdata = (reg_sel == SEL_DATA) ? rxbuf_q : ctrl_q;
  assign ti        = ctrl_q[CB_TXF];
  assign ri        = ctrl_q[CB_RXF];

endmodule

// File: rtl/srl_port_chk.sv
module srl_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic              txd,
  input logic              ti,
  input logic              ri,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] rx_buf
);

  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_sel == 1'b0);

  // R3: hardware raises the transmit-done flag only right after a stop bit
  assert_ti_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti) && !$past(ctrl_wr)) |-> $past(txd));

  // R2: flags only fall through a control write
  assert_ti_fall_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ti) |-> $past(ctrl_wr));

  assert_ri_fall_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri) |-> $past(ctrl_wr));

  // R7: reception needs the receive enable
  assert_ri_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && !$past(ctrl_wr)) |-> $past(ctrl[4]));

  // R10: filtered nine-bit reception accepts only a set ninth bit
  assert_filter_ninth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && !$past(ctrl_wr) && $past(ctrl[5]) && $past(ctrl[7])) |-> ctrl[2]);

  // R12: the data location holds while the receive flag is set
  assert_hold_while_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ri) |-> $stable(rx_buf));

  // R13: mode 00 keeps the line idle
  assert_off_line_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[7:6]) == 2'b00) |-> txd);

endmodule

bind srl_port srl_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_sel (reg_sel),
  .reg_wr  (reg_wr),
  .txd     (txd),
  .ti      (ti),
  .ri      (ri),
  .ctrl    (ctrl_q),
  .rx_buf  (rxbuf_q)
);

// File: tb/tb_srl_port.sv
`timescale 1ns/1ps
module tb_srl_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       t1_ovf = 1'b0;
  logic       smod = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd = 1'b1;
  logic       txd, ti, ri;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int ovf_every = 1;
  int ovf_cnt = 0;

  always #2.5 clk = ~clk;

  srl_port dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .t1_ovf(t1_ovf), .smod(smod),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .ti(ti), .ri(ri)
  );

  always @(negedge clk) begin
    if (ovf_cnt >= ovf_every - 1) begin
      ovf_cnt = 0;
      t1_ovf  = 1'b1;
    end else begin
      ovf_cnt = ovf_cnt + 1;
      t1_ovf  = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic int bit_len(input logic [1:0] m, input logic sm);
    if (m == 2'b10) return sm ? 32 : 64;
    return (sm ? 16 : 32) * ovf_every;
  endfunction

  task automatic run_tx(input logic [1:0] m, input logic sm, input logic [7:0] d, input logic b9);
    int bl, p, nb, e, t;
    logic [7:0] got;
    logic st, sp, g9;
    string tag;
    bl = bit_len(m, sm); p = bl / 16; nb = m[1] ? 11 : 10;
    tag = m[1] ? "R4" : "R3";
    smod = sm;
    wr(1'b0, {m, 2'b00, b9, 3'b000});
    wr(1'b1, d);
    t = 0;
    while (txd !== 1'b0 && t < 300) begin @(negedge clk); t++; end
    e = 0;
    repeat (bl / 2) @(negedge clk);
    e += bl / 2;
    st = txd;
    chk(st === 1'b0, tag, "start bit", st, 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      repeat (bl) @(negedge clk);
      e += bl;
      got[i] = txd;
    end
    chk(got === d, tag, "data bits", got, d);
    if (m[1]) begin
      repeat (bl) @(negedge clk);
      e += bl;
      g9 = txd;
      chk(g9 === b9, "R4", "ninth bit", g9, b9);
    end
    repeat (bl) @(negedge clk);
    e += bl;
    sp = txd;
    chk(sp === 1'b1, tag, "stop bit", sp, 1);
    chk(ti === 1'b0, "R3", "done flag early", ti, 0);
    while (ti !== 1'b1 && e < nb * bl + bl) begin @(negedge clk); e++; end
    chk(ti === 1'b1, "R3", "done flag set", ti, 1);
    chk(e >= nb * bl - p && e <= nb * bl + 1, "R5", "frame duration", e, nb * bl);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9,
                         input logic stp, input int bl, input logic [7:0] glitch);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (glitch[i]) begin
        repeat (10) @(negedge clk);
        rxd = ~d[i];
        @(negedge clk);
        rxd = d[i];
        repeat (bl - 11) @(negedge clk);
      end else begin
        repeat (bl) @(negedge clk);
      end
    end
    if (nine) begin
      rxd = b9;
      repeat (bl) @(negedge clk);
    end
    rxd = stp;
    repeat (bl) @(negedge clk);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  logic [7:0] v, pats [4];

  initial begin
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h01;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v === 8'h00, "R1", "control after reset", v, 0);
    rd(1'b1, v); chk(v === 8'h00, "R1", "data after reset", v, 0);
    chk(txd === 1'b1, "R1", "txd idle", txd, 1);
    chk(ti === 1'b0 && ri === 1'b0, "R1", "flags clear", {ti, ri}, 0);

    // R2 register layout and software flag access
    wr(1'b0, 8'h5B);
    rd(1'b0, v); chk(v === 8'h5B, "R2", "control readback", v, 8'h5B);
    chk(ti === 1'b1 && ri === 1'b1, "R2", "flags from bits 1 and 0", {ti, ri}, 3);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk(v === 8'h00, "R2", "control clear", v, 0);

    // R3 R4 R5 transmit sweep
    for (int m = 1; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          run_tx(2'(m), 1'(s), pats[k] ^ 8'(m * 16 + s), 1'(k));
    ovf_every = 2;
    run_tx(2'b01, 1'b1, 8'h96, 1'b0);
    run_tx(2'b11, 1'b0, 8'h69, 1'b1);
    ovf_every = 1;

    // R6 receive sweep
    for (int m = 1; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] d;
          logic b9, exp9;
          d = pats[k] ^ 8'(m * 3 + s);
          b9 = 1'(k + s);
          exp9 = (m == 1) ? 1'b1 : b9;
          smod = 1'(s);
          wr(1'b0, {2'(m), 2'b01, 4'b0000});
          send_rx(d, 1'(m >> 1), b9, 1'b1, bit_len(2'(m), 1'(s)), 8'h00);
          chk(ri === 1'b1, "R6", "receive flag", ri, 1);
          rd(1'b1, v); chk(v === d, "R6", "received data", v, d);
          rd(1'b0, v); chk(v[2] === exp9, "R6", "received ninth", v[2], exp9);
        end
    smod = 1'b1;
    wr(1'b0, 8'h50);
    send_rx(8'hC3, 1'b0, 1'b0, 1'b0, 16, 8'h00);
    repeat (40) @(negedge clk);
    rd(1'b1, v); chk(v === 8'hC3 && ri === 1'b1, "R6", "zero stop accepted", v, 8'hC3);
    rd(1'b0, v); chk(v[2] === 1'b0, "R6", "zero stop in bit 2", v[2], 0);

    // R7 receive disabled
    wr(1'b0, 8'h40);
    send_rx(8'h5E, 1'b0, 1'b0, 1'b1, 16, 8'h00);
    chk(ri === 1'b0, "R7", "no flag when disabled", ri, 0);
    rd(1'b1, v); chk(v === 8'hC3, "R7", "data unchanged", v, 8'hC3);

    // R8 false start then valid frame
    wr(1'b0, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk(ri === 1'b0, "R8", "false start ignored", ri, 0);
    rd(1'b1, v); chk(v === 8'hC3, "R8", "data unchanged", v, 8'hC3);
    send_rx(8'h7A, 1'b0, 1'b0, 1'b1, 16, 8'h00);
    rd(1'b1, v); chk(v === 8'h7A && ri === 1'b1, "R8", "frame after false start", v, 8'h7A);

    // R9 majority vote
    wr(1'b0, 8'h50);
    send_rx(8'h55, 1'b0, 1'b0, 1'b1, 16, 8'h3C);
    rd(1'b1, v); chk(v === 8'h55, "R9", "glitched bits voted", v, 8'h55);

    // R10 filter in nine-bit modes
    for (int m = 2; m < 4; m++) begin
      smod = 1'b1;
      wr(1'b0, {2'(m), 2'b11, 4'b0000});
      send_rx(8'h12, 1'b1, 1'b0, 1'b1, bit_len(2'(m), 1'b1), 8'h00);
      chk(ri === 1'b0, "R10", "ninth 0 dropped", ri, 0);
      rd(1'b1, v); chk(v === 8'h55, "R10", "data kept", v, 8'h55);
      send_rx(8'h55, 1'b1, 1'b1, 1'b1, bit_len(2'(m), 1'b1), 8'h00);
      rd(1'b0, v); chk(v[0] === 1'b1 && v[2] === 1'b1, "R10", "ninth 1 accepted", v, 8'h05);
    end

    // R11 filter in mode 01
    wr(1'b0, 8'h70);
    send_rx(8'h21, 1'b0, 1'b0, 1'b0, 16, 8'h00);
    repeat (40) @(negedge clk);
    chk(ri === 1'b0, "R11", "bad stop dropped", ri, 0);
    send_rx(8'h84, 1'b0, 1'b0, 1'b1, 16, 8'h00);
    rd(1'b1, v); chk(v === 8'h84 && ri === 1'b1, "R11", "good stop accepted", v, 8'h84);

    // R12 overrun drop
    wr(1'b0, 8'hD0);
    send_rx(8'hE7, 1'b1, 1'b1, 1'b1, 16, 8'h00);
    send_rx(8'h18, 1'b1, 1'b0, 1'b1, 16, 8'h00);
    rd(1'b1, v); chk(v === 8'hE7, "R12", "data kept while flag set", v, 8'hE7);
    rd(1'b0, v); chk(v[2] === 1'b1 && v[0] === 1'b1, "R12", "ninth kept", v, 8'hD5);

    // R13 mode 00 inert
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h00);
    begin
      bit low_seen;
      low_seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) low_seen = 1'b1;
      end
      chk(!low_seen, "R13", "txd stays idle", low_seen, 0);
    end
    chk(ti === 1'b0, "R13", "no done flag", ti, 0);
    send_rx(8'h0F, 1'b0, 1'b0, 1'b1, 16, 8'h00);
    chk(ri === 1'b0, "R13", "no reception", ri, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule